// File: doc/BRIEF.md
# Banked Extended RAM Burst Port

This block gives a host on a narrow byte-wide register bus access to a battery-backed extended RAM. The RAM has no address range of its own on that bus. The host first sets a bank-select bit in a shared control byte. It then loads a RAM pointer through two address registers and moves bytes through one data-port register.

When burst mode is on, every data-port access moves the pointer forward by one after it completes. A run of bytes can then be streamed without reloading the address. When the bank bit is clear, the upper half of the register space maps to a small ordinary scratch RAM instead, and the extended port keeps its state.

The RAM depth is a parameter and may be 128, 2048, 4096 or 8192 bytes. A register or RAM read returns its byte on `rdata_o` one clock after the read strobe. The byte then holds until the next read.

Top module: `xram_burst_port`

## Requirements
- R1: The control byte at offset 0x0A reads and writes in both banks, and its bit 4 selects the extended bank when 1.
- R2: In the extended bank, offset 0x50 holds pointer bits 7:0 and offset 0x51 holds pointer bits 15:8. Pointer bits at or above log2(DEPTH) are dropped on write and read back as 0.
- R3: In the extended bank, a write to offset 0x53 stores the byte at the pointer, and a read of 0x53 returns the byte at the pointer.
- R4: In the extended bank, bit 5 of offset 0x4A is the burst enable, and every other bit of 0x4A reads 0.
- R5: With burst enabled, each data-port read or write advances the pointer by one after the access, and the pointer wraps modulo DEPTH. The next access therefore uses the new address.
- R6: With burst disabled, the pointer keeps its value across data-port accesses.
- R7: With the bank bit at 0, offsets 0x40 to 0x7F reach a 64-byte scratch RAM. Accesses there change neither the pointer, nor the burst bit, nor the extended RAM contents.
- R8: Unmapped offsets read 0 and ignore writes. These are offsets 0x00 to 0x3F other than 0x0A, and, in the extended bank, the upper-half offsets other than 0x4A, 0x50, 0x51 and 0x53.
- R9: After reset, the control byte, the pointer and the burst bit all read 0.
- R10: Read data appears on `rdata_o` in the cycle after the read strobe and holds until the next read. When `wr_i` and `rd_i` are both high, only the write takes effect and `rdata_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data, valid one cycle after rd_i |

## Verification
A wrong pointer shows up on the very next data-port read as a byte from the wrong location. It also shows up one cycle after a read of 0x50 or 0x51, so the tests read the pointer back after each burst run and each wrap. A burst bit that sticks or drops shows as a repeated or skipped byte in a streamed read-back within one access. Leakage between banks is exposed by writing the scratch RAM at the same offsets and then checking that the extended pointer, the burst bit and the RAM contents are unchanged one cycle after the return to the extended bank.

// File: rtl/xram_port_pkg.sv
package xram_port_pkg;
  localparam logic [6:0] OFS_CTL  = 7'h0A;
  localparam logic [6:0] OFS_XCTL = 7'h4A;
  localparam logic [6:0] OFS_ALO  = 7'h50;
  localparam logic [6:0] OFS_AHI  = 7'h51;
  localparam logic [6:0] OFS_PORT = 7'h53;
  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;
  localparam int B0_DEPTH  = 64;

  typedef enum logic [2:0] {
    RS_ZERO, RS_CTL, RS_XCTL, RS_ALO, RS_AHI, RS_XRAM, RS_B0
  } rd_sel_e;

  typedef struct packed {
    logic ctl_we;
    logic xctl_we;
    logic alo_we;
    logic ahi_we;
    logic port_we;
    logic port_re;
    logic b0_we;
    logic b0_re;
  } strobe_t;

  function automatic bit depth_ok(int d);
    return (d == 128) || (d == 2048) || (d == 4096) || (d == 8192);
  endfunction
endpackage

// File: rtl/xram_port_decode.sv
module xram_port_decode
  import xram_port_pkg::*;
(
  input  logic       bank_i,
  input  logic [6:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output strobe_t    stb_o,
  output rd_sel_e    sel_o,
  output logic       rd_o
);
  logic rd_ok;
  assign rd_ok = rd_i & ~wr_i;  // write wins on collision
  assign rd_o  = rd_ok;

  always_comb begin
    stb_o = '0;
    sel_o = RS_ZERO;
    if (addr_i == OFS_CTL) begin
      stb_o.ctl_we = wr_i;
      sel_o        = RS_CTL;
    end else if (addr_i[6] && !bank_i) begin
      stb_o.b0_we = wr_i;
      stb_o.b0_re = rd_ok;
      sel_o       = RS_B0;
    end else if (addr_i[6]) begin
      unique case (addr_i)
        OFS_XCTL: begin stb_o.xctl_we = wr_i; sel_o = RS_XCTL; end
        OFS_ALO:  begin stb_o.alo_we  = wr_i; sel_o = RS_ALO;  end
        OFS_AHI:  begin stb_o.ahi_we  = wr_i; sel_o = RS_AHI;  end
        OFS_PORT: begin
          stb_o.port_we = wr_i;
          stb_o.port_re = rd_ok;
          sel_o         = RS_XRAM;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xram_addr_ptr.sv
module xram_addr_ptr #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_lo_i,
  input  logic          ld_hi_i,
  input  logic          step_i,
  input  logic [7:0]    wdata_i,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    lo_o,
  output logic [7:0]    hi_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [15:0]   cur16, nxt16;
  logic          unused_hi;

  assign cur16 = 16'(addr_q);
  assign lo_o  = cur16[7:0];
  assign hi_o  = cur16[15:8];

  always_comb begin
    nxt16 = cur16;
    if (ld_lo_i) nxt16[7:0]  = wdata_i;
    if (ld_hi_i) nxt16[15:8] = wdata_i;
    addr_d = nxt16[AW-1:0];
    if (step_i) addr_d = addr_q + {{(AW-1){1'b0}}, 1'b1};
  end
  assign unused_hi = ^nxt16[15:AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end
  assign addr_o = addr_q;

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_lo_i || ld_hi_i || step_i) |=> $stable(addr_q));
  // R5
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_lo_i && !ld_hi_i) |=> addr_q == $past(addr_q) + AW'(1));
endmodule

// File: rtl/xram_mem.sv
module xram_mem #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/xram_burst_port.sv
module xram_burst_port
  import xram_port_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int B0AW = $clog2(B0_DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o
);
  if (!depth_ok(DEPTH)) begin : g_bad_depth
    $error("xram_burst_port: DEPTH must be 128, 2048, 4096 or 8192");
  end

  logic [7:0]    ctl_q, reg_q, reg_d, xram_q, b0_q, alo, ahi;
  logic          burst_q, rd_ok, step;
  logic [AW-1:0] xaddr;
  strobe_t       stb;
  rd_sel_e       sel, sel_q;

  xram_port_decode i_decode (
    .bank_i (ctl_q[BANK_BIT]),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .stb_o  (stb),
    .sel_o  (sel),
    .rd_o   (rd_ok)
  );

  assign step = burst_q & (stb.port_we | stb.port_re);

  xram_addr_ptr #(.AW(AW)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_lo_i (stb.alo_we),
    .ld_hi_i (stb.ahi_we),
    .step_i  (step),
    .wdata_i (wdata_i),
    .addr_o  (xaddr),
    .lo_o    (alo),
    .hi_o    (ahi)
  );

  xram_mem #(.DEPTH(DEPTH)) i_xram (
    .clk_i   (clk_i),
    .we_i    (stb.port_we),
    .re_i    (stb.port_re),
    .addr_i  (xaddr),
    .wdata_i (wdata_i),
    .rdata_o (xram_q)
  );

  xram_mem #(.DEPTH(B0_DEPTH)) i_b0ram (
    .clk_i   (clk_i),
    .we_i    (stb.b0_we),
    .re_i    (stb.b0_re),
    .addr_i  (addr_i[B0AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (b0_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      burst_q <= 1'b0;
    end else begin
      if (stb.ctl_we)  ctl_q   <= wdata_i;
      if (stb.xctl_we) burst_q <= wdata_i[BURST_BIT];
    end
  end

  always_comb begin
    unique case (sel)
      RS_CTL:  reg_d = ctl_q;
      RS_XCTL: reg_d = 8'(burst_q) << BURST_BIT;
      RS_ALO:  reg_d = alo;
      RS_AHI:  reg_d = ahi;
      default: reg_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= RS_ZERO;
      reg_q <= '0;
    end else if (rd_ok) begin
      sel_q <= sel;
      reg_q <= reg_d;
    end
  end

  always_comb begin
    unique case (sel_q)
      RS_XRAM: rdata_o = xram_q;
      RS_B0:   rdata_o = b0_q;
      default: rdata_o = reg_q;
    endcase
  end

  // R7
  bank0_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[BANK_BIT] && (wr_i || rd_i)) |=> ($stable(xaddr) && $stable(burst_q)));
  // R7
  ram_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stb.port_we, stb.b0_we, stb.port_re, stb.b0_re}));
  // R10
  collide_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i) |=> $stable(rdata_o));
endmodule

// File: tb/test_xram_burst_port.sv
module test_xram_burst_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 61;
  // entry: {wr,rd, offset[6:0], wdata[7:0], check, expect[7:0], req[3:0]}
  localparam logic [29:0] VEC [NV] = '{
    {2'b01,7'h0A,8'h00,1'b1,8'h00,4'd9},   // R9 control byte after reset
    {2'b10,7'h0A,8'h10,1'b0,8'h00,4'd1},
    {2'b01,7'h0A,8'h00,1'b1,8'h10,4'd1},   // R1
    {2'b01,7'h50,8'h00,1'b1,8'h00,4'd9},   // R9 pointer
    {2'b01,7'h51,8'h00,1'b1,8'h00,4'd9},
    {2'b01,7'h4A,8'h00,1'b1,8'h00,4'd9},   // R9 burst
    {2'b10,7'h51,8'h03,1'b0,8'h00,4'd2},
    {2'b10,7'h50,8'hFE,1'b0,8'h00,4'd2},
    {2'b01,7'h51,8'h00,1'b1,8'h03,4'd2},   // R2
    {2'b01,7'h50,8'h00,1'b1,8'hFE,4'd2},
    {2'b10,7'h4A,8'hFF,1'b0,8'h00,4'd4},
    {2'b01,7'h4A,8'h00,1'b1,8'h20,4'd4},   // R4
    {2'b10,7'h53,8'hA1,1'b0,8'h00,4'd5},
    {2'b10,7'h53,8'hA2,1'b0,8'h00,4'd5},
    {2'b10,7'h53,8'hA3,1'b0,8'h00,4'd5},
    {2'b01,7'h50,8'h00,1'b1,8'h01,4'd5},   // R5 pointer 0x401
    {2'b01,7'h51,8'h00,1'b1,8'h04,4'd5},
    {2'b10,7'h50,8'hFE,1'b0,8'h00,4'd5},
    {2'b10,7'h51,8'h03,1'b0,8'h00,4'd5},
    {2'b01,7'h53,8'h00,1'b1,8'hA1,4'd5},   // R5 streamed read R3
    {2'b01,7'h53,8'h00,1'b1,8'hA2,4'd5},
    {2'b01,7'h53,8'h00,1'b1,8'hA3,4'd5},
    {2'b10,7'h4A,8'h00,1'b0,8'h00,4'd6},
    {2'b10,7'h50,8'hFE,1'b0,8'h00,4'd6},
    {2'b10,7'h51,8'h03,1'b0,8'h00,4'd6},
    {2'b01,7'h53,8'h00,1'b1,8'hA1,4'd6},   // R6
    {2'b01,7'h53,8'h00,1'b1,8'hA1,4'd6},
    {2'b10,7'h53,8'h5A,1'b0,8'h00,4'd3},
    {2'b01,7'h53,8'h00,1'b1,8'h5A,4'd3},   // R3 overwrite
    {2'b01,7'h50,8'h00,1'b1,8'hFE,4'd6},
    {2'b10,7'h51,8'hFF,1'b0,8'h00,4'd2},
    {2'b01,7'h51,8'h00,1'b1,8'h07,4'd2},   // R2 upper bits dropped
    {2'b10,7'h50,8'hFF,1'b0,8'h00,4'd5},
    {2'b10,7'h4A,8'h20,1'b0,8'h00,4'd5},
    {2'b10,7'h53,8'hC7,1'b0,8'h00,4'd5},
    {2'b10,7'h53,8'hC0,1'b0,8'h00,4'd5},
    {2'b01,7'h50,8'h00,1'b1,8'h01,4'd5},   // R5 wrap
    {2'b01,7'h51,8'h00,1'b1,8'h00,4'd5},
    {2'b10,7'h50,8'h00,1'b0,8'h00,4'd5},
    {2'b01,7'h53,8'h00,1'b1,8'hC0,4'd5},
    {2'b10,7'h52,8'h99,1'b0,8'h00,4'd8},
    {2'b01,7'h52,8'h00,1'b1,8'h00,4'd8},   // R8
    {2'b01,7'h40,8'h00,1'b1,8'h00,4'd8},
    {2'b10,7'h20,8'h55,1'b0,8'h00,4'd8},
    {2'b01,7'h20,8'h00,1'b1,8'h00,4'd8},
    {2'b10,7'h0A,8'h00,1'b0,8'h00,4'd7},
    {2'b10,7'h53,8'h77,1'b0,8'h00,4'd7},
    {2'b10,7'h50,8'h66,1'b0,8'h00,4'd7},
    {2'b10,7'h4A,8'h00,1'b0,8'h00,4'd7},
    {2'b01,7'h53,8'h00,1'b1,8'h77,4'd7},   // R7 scratch RAM
    {2'b01,7'h50,8'h00,1'b1,8'h66,4'd7},
    {2'b01,7'h4A,8'h00,1'b1,8'h00,4'd7},
    {2'b10,7'h0A,8'h10,1'b0,8'h00,4'd7},
    {2'b01,7'h50,8'h00,1'b1,8'h01,4'd7},   // R7 pointer kept
    {2'b01,7'h4A,8'h00,1'b1,8'h20,4'd7},   // R7 burst kept
    {2'b10,7'h50,8'h00,1'b0,8'h00,4'd7},
    {2'b01,7'h53,8'h00,1'b1,8'hC0,4'd7},   // R7 ext RAM kept
    {2'b11,7'h53,8'h33,1'b1,8'hC0,4'd10},  // R10 collision
    {2'b01,7'h50,8'h00,1'b1,8'h02,4'd10},
    {2'b10,7'h50,8'h01,1'b0,8'h00,4'd10},
    {2'b01,7'h53,8'h00,1'b1,8'h33,4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_burst_port i_xram_burst_port (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wdata_i (wdata),
    .wr_i (wr), .rd_i (rd), .rdata_o (rdata)
  );

  task automatic op(input logic w, input logic r, input logic [6:0] a, input logic [7:0] d);
    wr = w; rd = r; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic check(input logic [7:0] exp, input int req);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL R%0d: rdata=%02h expected=%02h", req, rdata, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R9 output after reset
    if (rdata !== 8'h00) begin
      errors++;
      $display("FAIL R9: rdata=%02h expected=00", rdata);
    end
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][29], VEC[i][28], VEC[i][27:21], VEC[i][20:13]);
      if (VEC[i][12]) check(VEC[i][11:4], int'(VEC[i][3:0]));
    end
    // R9 mid-run reset clears control, pointer and burst
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    op(1'b0, 1'b1, 7'h0A, 8'h00); check(8'h00, 9);
    op(1'b1, 1'b0, 7'h0A, 8'h10);
    op(1'b0, 1'b1, 7'h50, 8'h00); check(8'h00, 9);
    op(1'b0, 1'b1, 7'h51, 8'h00); check(8'h00, 9);
    op(1'b0, 1'b1, 7'h4A, 8'h00); check(8'h00, 9);
    // R10 data holds with idle bus
    op(1'b1, 1'b0, 7'h0A, 8'h10);
    repeat (3) @(negedge clk);
    check(8'h00, 10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule